// File: doc/BRIEF.md
# Interval Timer Control Word and Readout Unit

This block is the host-side register front end of a three-channel interval timer. A processor writes byte-wide control words and count bytes over an 8-bit bus and reads byte-wide results back. The block keeps each channel's configuration, gathers count bytes into full reload values, and gives each counting channel a one-cycle load strobe, a one-cycle configuration strobe, and the settled mode and BCD select. Each channel's live count and OUT level come back into the block.

A free-running count changes between two byte reads. Software gets a consistent value in one of two ways. It can freeze a single channel's count with a snapshot command. It can also use a group command that freezes the count, a status byte, or both, for any set of channels. A frozen value is held until it has been read out completely. Reads and writes to one channel use separate byte pointers, so they can be interleaved freely. The strobes `wr_en` and `rd_en` are single-cycle and never asserted together.

Top module: `pit_regif`

## Requirements
- R1: A write to address 3 with bits 7:6 naming a channel (0 to 2) and bits 5:4 non-zero is a control word. In the following cycle, that channel's `ch_cfg` bit is high for exactly one cycle. Its `ch_bcd` then equals bit 0 of the word.
- R2: The mode field is bits 3:1. Codes 6 and 7 are reported on `ch_mode` as 2 and 3. Every other code is reported unchanged.
- R3: Access mode is bits 5:4 of the control word. With access 01, one write of byte d to a channel's address (0 to 2) loads 0x00d. With access 10, it loads d00. In both cases `ch_load` pulses in the cycle after the write.
- R4: With access 11, the first data write is held as the low byte and gives no load. The second write loads {second, first}. A control word resets this write pointer.
- R5: Without a snapshot, a read of a channel returns a byte of its live count. Access 01 gives the low byte, 10 gives the high byte, and 11 gives low then high on alternate reads. `rdata` changes only in the cycle after a read strobe.
- R6: A control word with bits 5:4 = 00 freezes that channel's count. Reads return bytes of the frozen value until the last byte for the access mode has been read. After that, reads return the live count again.
- R7: A snapshot command for a channel that already holds a frozen count has no effect.
- R8: A write with bits 7:6 = 11 is a group command. Bit 5 = 0 freezes counts and bit 4 = 0 freezes status. Bits 1, 2 and 3 select channels 0, 1 and 2.
- R9: The status byte holds the following. Bit 7 is the channel's OUT level when frozen. Bit 6 is a pending flag, set by a control word and cleared by a count load. Bits 5:0 are bits 5:0 of the last control word. A frozen status is read before a frozen count.
- R10: After reset, every channel has access mode 11, mode 0, binary counting and the pending flag set. No strobe is active and `rdata` is 0.
- R11: A read of address 3 returns 0x00. At most one channel's `ch_load` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | 0 to 2 select a channel, 3 is the command register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| ch_count | input | NCH*CNT_W | Live count of each channel |
| ch_out | input | NCH | OUT level of each channel |
| ch_cfg | output | NCH | One-cycle strobe on a new control word |
| ch_mode | output | NCH*3 | Folded mode of each channel |
| ch_bcd | output | NCH | BCD select of each channel |
| ch_load | output | NCH | One-cycle reload strobe |
| ch_load_val | output | NCH*CNT_W | Reload value, held after the strobe |

## Verification
Each access mode is exercised with both writes and reads. The bench compares load values byte for byte, so it can tell a swapped low/high byte from a pointer that is never reset. Snapshot reads are mixed with changes to the live count. This separates a held value from a live one, and it shows whether a second snapshot is wrongly taken. Group commands cover count only, status only, and both on chosen channels. They show the read order of status and count, and that unselected channels stay live.

// File: rtl/pit_regif_pkg.sv
package pit_regif_pkg;

   typedef enum logic [1:0] {
      ACC_SNAP = 2'b00,
      ACC_LO   = 2'b01,
      ACC_HI   = 2'b10,
      ACC_WORD = 2'b11
   } acc_e;

   typedef struct packed {
      logic       grp;        // group command
      logic [1:0] sel;
      acc_e       acc;
      logic [2:0] mode;       // already folded
      logic       bcd;
      logic       skip_cnt;
      logic       skip_st;
      logic [2:0] mask;
      logic [5:0] raw;
   } cmd_t;

   function automatic logic [2:0] fold_mode(input logic [2:0] m);
      return m[1] ? {1'b0, m[1:0]} : m;
   endfunction

endpackage

// File: rtl/pit_cmd_decode.sv
module pit_cmd_decode
   import pit_regif_pkg::*;
(
   input  logic [7:0] byte_in,
   output cmd_t       cmd
);
   always_comb begin
      cmd.grp      = (byte_in[7:6] == 2'b11);
      cmd.sel      = byte_in[7:6];
      cmd.acc      = acc_e'(byte_in[5:4]);
      cmd.mode     = fold_mode(byte_in[3:1]);
      cmd.bcd      = byte_in[0];
      cmd.skip_cnt = byte_in[5];
      cmd.skip_st  = byte_in[4];
      cmd.mask     = byte_in[3:1];
      cmd.raw      = byte_in[5:0];
   end
endmodule

// File: rtl/pit_chan_regs.sv
module pit_chan_regs
   import pit_regif_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  cmd_t             cmd,
   input  logic             snap_cmd,
   input  logic             stat_cmd,
   input  logic             data_wr,
   input  logic             data_rd,
   input  logic [7:0]       wdata,
   input  logic [CNT_W-1:0] count,
   input  logic             out_lvl,
   output logic [7:0]       rd_byte,
   output logic             cfg_pulse,
   output logic [2:0]       mode,
   output logic             bcd,
   output logic             load,
   output logic [CNT_W-1:0] load_val
);
   localparam int PAD_W = 16 - CNT_W;

   acc_e             acc;
   logic [5:0]       raw;
   logic             pend;
   logic             wr_ptr, rd_ptr;
   logic [7:0]       lo_hold;
   logic             cnt_held, st_held;
   logic [CNT_W-1:0] cnt_snap;
   logic [7:0]       st_snap;
   logic [CNT_W-1:0] src;
   logic [7:0]       src_lo, src_hi;
   logic             pick_hi, last_byte;
   logic [15:0]      word;

   assign src    = cnt_held ? cnt_snap : count;
   assign src_lo = src[7:0];

   generate
      if (PAD_W == 0) begin : g_full_hi
         assign src_hi = src[15:8];
      end else begin : g_pad_hi
         assign src_hi = {{PAD_W{1'b0}}, src[CNT_W-1:8]};
      end
   endgenerate

   assign pick_hi   = (acc == ACC_HI) || (acc == ACC_WORD && rd_ptr);
   assign last_byte = (acc != ACC_WORD) || rd_ptr;
   assign rd_byte   = st_held ? st_snap : (pick_hi ? src_hi : src_lo);

   always_comb begin
      unique case (acc)
         ACC_HI:   word = {wdata, 8'h00};
         ACC_WORD: word = {wdata, lo_hold};
         default:  word = {8'h00, wdata};
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc       <= ACC_WORD;
         raw       <= 6'b110000;
         mode      <= 3'd0;
         bcd       <= 1'b0;
         pend      <= 1'b1;
         wr_ptr    <= 1'b0;
         rd_ptr    <= 1'b0;
         lo_hold   <= 8'h00;
         cnt_held  <= 1'b0;
         st_held   <= 1'b0;
         cnt_snap  <= '0;
         st_snap   <= 8'h00;
         cfg_pulse <= 1'b0;
         load      <= 1'b0;
         load_val  <= '0;
      end else begin
         cfg_pulse <= 1'b0;
         load      <= 1'b0;
         if (cfg_wr) begin
            acc       <= cmd.acc;
            raw       <= cmd.raw;
            mode      <= cmd.mode;
            bcd       <= cmd.bcd;
            pend      <= 1'b1;
            wr_ptr    <= 1'b0;
            rd_ptr    <= 1'b0;
            cnt_held  <= 1'b0;
            st_held   <= 1'b0;
            cfg_pulse <= 1'b1;
         end else begin
            if (snap_cmd && !cnt_held) begin
               cnt_snap <= count;
               cnt_held <= 1'b1;
            end
            if (stat_cmd && !st_held) begin
               st_snap <= {out_lvl, pend, raw};
               st_held <= 1'b1;
            end
            if (data_wr) begin
               if (acc == ACC_WORD && !wr_ptr) begin
                  lo_hold <= wdata;
                  wr_ptr  <= 1'b1;
               end else begin
                  wr_ptr   <= 1'b0;
                  load     <= 1'b1;
                  load_val <= word[CNT_W-1:0];
                  pend     <= 1'b0;
               end
            end
            if (data_rd) begin
               if (st_held) begin
                  st_held <= 1'b0;
               end else begin
                  if (acc == ACC_WORD) rd_ptr <= ~rd_ptr;
                  if (cnt_held && last_byte) cnt_held <= 1'b0;
               end
            end
         end
      end
   end
endmodule

// File: rtl/pit_regif.sv
module pit_regif
   import pit_regif_pkg::*;
#(
   parameter int NCH   = 3,
   parameter int CNT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [1:0]           addr,
   input  logic [7:0]           wdata,
   output logic [7:0]           rdata,
   input  logic [NCH*CNT_W-1:0] ch_count,
   input  logic [NCH-1:0]       ch_out,
   output logic [NCH-1:0]       ch_cfg,
   output logic [NCH*3-1:0]     ch_mode,
   output logic [NCH-1:0]       ch_bcd,
   output logic [NCH-1:0]       ch_load,
   output logic [NCH*CNT_W-1:0] ch_load_val
);
   localparam logic [1:0] CMD_ADDR = 2'd3;

   generate
      if (NCH < 1 || NCH > 3) begin : g_bad_nch
         $error("pit_regif: NCH must be 1 to 3");
      end
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt_w
         $error("pit_regif: CNT_W must be 9 to 16");
      end
   endgenerate

   cmd_t       cmd;
   logic       cmd_wr;
   logic [7:0] ch_byte [NCH];

   assign cmd_wr = wr_en && (addr == CMD_ADDR);

   pit_cmd_decode u_dec (
      .byte_in (wdata),
      .cmd     (cmd)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic hit, cfg_wr, snap_cmd, stat_cmd;

      assign hit      = !cmd.grp && (cmd.sel == 2'(i));
      assign cfg_wr   = cmd_wr && hit && (cmd.acc != ACC_SNAP);
      assign snap_cmd = cmd_wr && ((hit && cmd.acc == ACC_SNAP) ||
                                   (cmd.grp && !cmd.skip_cnt && cmd.mask[i]));
      assign stat_cmd = cmd_wr && cmd.grp && !cmd.skip_st && cmd.mask[i];

      pit_chan_regs #(.CNT_W(CNT_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .cfg_wr    (cfg_wr),
         .cmd       (cmd),
         .snap_cmd  (snap_cmd),
         .stat_cmd  (stat_cmd),
         .data_wr   (wr_en && addr == 2'(i)),
         .data_rd   (rd_en && addr == 2'(i)),
         .wdata     (wdata),
         .count     (ch_count[i*CNT_W +: CNT_W]),
         .out_lvl   (ch_out[i]),
         .rd_byte   (ch_byte[i]),
         .cfg_pulse (ch_cfg[i]),
         .mode      (ch_mode[i*3 +: 3]),
         .bcd       (ch_bcd[i]),
         .load      (ch_load[i]),
         .load_val  (ch_load_val[i*CNT_W +: CNT_W])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= 8'h00;
      end else if (rd_en) begin
         rdata <= 8'h00;
         for (int k = 0; k < NCH; k++)
            if (addr == 2'(k)) rdata <= ch_byte[k];
      end
   end
endmodule

// File: rtl/pit_regif_chk.sv
module pit_regif_chk #(
   parameter int NCH   = 3,
   parameter int CNT_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic                 rd_en,
   input logic [1:0]           addr,
   input logic [7:0]           wdata,
   input logic [7:0]           rdata,
   input logic [NCH-1:0]       ch_cfg,
   input logic [NCH*3-1:0]     ch_mode,
   input logic [NCH-1:0]       ch_load
);
   a_r1_cfg_after_cw: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3 && wdata[7:6] != 2'b11 && wdata[5:4] != 2'b00
       && int'(wdata[7:6]) < NCH) |=> ($countones(ch_cfg) == 1));

   a_r1_cfg_needs_cw: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_cfg != '0) |-> $past(wr_en && addr == 2'd3));

   a_r3_load_needs_data_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_load != '0) |-> $past(wr_en && addr != 2'd3));

   a_r11_one_load: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ch_load));

   a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   for (genvar i = 0; i < NCH; i++) begin : g_mode
      a_r2_folded_mode: assert property (@(posedge clk) disable iff (!rst_n)
         ch_cfg[i] |-> !(ch_mode[i*3+2] && ch_mode[i*3+1]));
   end
endmodule

bind pit_regif pit_regif_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .rd_en   (rd_en),
   .addr    (addr),
   .wdata   (wdata),
   .rdata   (rdata),
   .ch_cfg  (ch_cfg),
   .ch_mode (ch_mode),
   .ch_load (ch_load)
);

// File: tb/tb_pit_regif.sv
module tb_pit_regif;
   localparam int NCH = 3;
   localparam int CW  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [15:0] cnt [NCH];
   logic [NCH-1:0] ch_out = '0;
   logic [NCH*CW-1:0] ch_count;
   logic [NCH-1:0] ch_cfg, ch_bcd, ch_load;
   logic [NCH*3-1:0] ch_mode;
   logic [NCH*CW-1:0] ch_load_val;

   int n_tests = 0, n_fail = 0;
   string cur_req = "R10";

   always #5 clk = ~clk;

   for (genvar g = 0; g < NCH; g++) begin : g_cnt
      assign ch_count[g*CW +: CW] = cnt[g];
   end

   pit_regif #(.NCH(NCH), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ch_count(ch_count), .ch_out(ch_out),
      .ch_cfg(ch_cfg), .ch_mode(ch_mode), .ch_bcd(ch_bcd), .ch_load(ch_load),
      .ch_load_val(ch_load_val)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_acc[NCH], m_mode[NCH], m_bcd[NCH], m_raw[NCH], m_pend[NCH];
   int m_wp[NCH], m_rp[NCH], m_lo[NCH], m_ch[NCH], m_snap[NCH];
   int m_sh[NCH], m_ss[NCH], e_val[NCH];
   int e_load, e_cfg, e_rdata;

   function automatic int rd_value(int c);
      int v;
      if (m_sh[c] != 0) return m_ss[c];
      v = (m_ch[c] != 0) ? m_snap[c] : int'(cnt[c]);
      if (m_acc[c] == 2 || (m_acc[c] == 3 && m_rp[c] == 1)) return (v >> 8) & 255;
      return v & 255;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_acc[c] = 3; m_mode[c] = 0; m_bcd[c] = 0; m_raw[c] = 'h30;
            m_pend[c] = 1; m_wp[c] = 0; m_rp[c] = 0; m_lo[c] = 0;
            m_ch[c] = 0; m_snap[c] = 0; m_sh[c] = 0; m_ss[c] = 0; e_val[c] = 0;
         end
         e_load = 0; e_cfg = 0; e_rdata = 0;
      end else begin
         e_load = 0; e_cfg = 0;
         if (wr_en && addr == 3) begin
            int s, a, m;
            s = wdata[7:6]; a = wdata[5:4]; m = wdata[3:1];
            if (s == 3) begin
               for (int c = 0; c < NCH; c++) if (wdata[c+1]) begin
                  if (!wdata[5] && m_ch[c] == 0) begin m_ch[c] = 1; m_snap[c] = cnt[c]; end
                  if (!wdata[4] && m_sh[c] == 0) begin
                     m_sh[c] = 1;
                     m_ss[c] = ch_out[c] * 128 + m_pend[c] * 64 + m_raw[c];
                  end
               end
            end else if (s < NCH) begin
               if (a == 0) begin
                  if (m_ch[s] == 0) begin m_ch[s] = 1; m_snap[s] = cnt[s]; end
               end else begin
                  m_acc[s] = a; m_raw[s] = wdata[5:0]; m_bcd[s] = wdata[0];
                  m_mode[s] = (m == 6 || m == 7) ? m - 4 : m;
                  m_pend[s] = 1; m_wp[s] = 0; m_rp[s] = 0; m_ch[s] = 0; m_sh[s] = 0;
                  e_cfg = 1 << s;
               end
            end
         end else if (wr_en && addr < NCH) begin
            int c;
            c = addr;
            if (m_acc[c] == 3 && m_wp[c] == 0) begin
               m_lo[c] = wdata; m_wp[c] = 1;
            end else begin
               if (m_acc[c] == 1) e_val[c] = wdata;
               else if (m_acc[c] == 2) e_val[c] = wdata * 256;
               else e_val[c] = wdata * 256 + m_lo[c];
               m_wp[c] = 0; m_pend[c] = 0; e_load = 1 << c;
            end
         end
         if (rd_en) begin
            if (addr >= NCH) e_rdata = 0;
            else begin
               int c;
               c = addr;
               e_rdata = rd_value(c);
               if (m_sh[c] != 0) m_sh[c] = 0;
               else begin
                  if (m_ch[c] != 0 && (m_acc[c] != 3 || m_rp[c] == 1)) m_ch[c] = 0;
                  if (m_acc[c] == 3) m_rp[c] = 1 - m_rp[c];
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk({cur_req, " load"}, int'(ch_load), e_load);
         chk({cur_req, " cfg"}, int'(ch_cfg), e_cfg);
         chk({cur_req, " rdata"}, int'(rdata), e_rdata);
         for (int c = 0; c < NCH; c++) begin
            chk({cur_req, " mode"}, int'(ch_mode[c*3 +: 3]), m_mode[c]);
            chk({cur_req, " bcd"}, int'(ch_bcd[c]), m_bcd[c]);
            chk({cur_req, " load_val"}, int'(ch_load_val[c*CW +: CW]), e_val[c]);
         end
      end
   end

   // ---------------- bus tasks ----------------
   task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0; d = rdata;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] b;
      for (int c = 0; c < NCH; c++) cnt[c] = 16'h0000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      cur_req = "R10";
      chk("R10 mode", int'(ch_mode), 0);
      chk("R10 load", int'(ch_load), 0);
      chk("R10 rdata", int'(rdata), 0);
      bus_wr(3, 8'hE2);                 // status only, ch0
      bus_rd(0, b);
      chk("R10 R9 reset status", b, 8'h70);

      cur_req = "R1";
      bus_wr(3, 8'h15);                 // ch0 lo-only, mode 2, bcd
      chk("R1 cfg pulse", ch_cfg, 3'b001);
      chk("R1 bcd", ch_bcd[0], 1);
      @(negedge clk);
      chk("R1 pulse one cycle", ch_cfg, 0);

      cur_req = "R3";
      bus_wr(0, 8'h5A);
      chk("R3 lo load", ch_load_val[15:0], 16'h005A);
      chk("R3 load strobe", ch_load, 3'b001);
      cur_req = "R2";
      bus_wr(3, 8'h6C);                 // ch1 hi-only, mode 6
      chk("R2 mode 6 folds", ch_mode[5:3], 2);
      cur_req = "R3";
      bus_wr(1, 8'h33);
      chk("R3 hi load", ch_load_val[31:16], 16'h3300);

      cur_req = "R4";
      bus_wr(3, 8'hBE);                 // ch2 word, mode 7
      chk("R2 mode 7 folds", ch_mode[8:6], 3);
      bus_wr(2, 8'h34);
      chk("R4 no load on first byte", ch_load, 0);
      bus_wr(2, 8'h12);
      chk("R4 word load", ch_load_val[47:32], 16'h1234);
      bus_wr(2, 8'h78);
      bus_wr(3, 8'hB0);                 // ch2 word, mode 0: pointer reset
      bus_wr(2, 8'h11);
      bus_wr(2, 8'h22);
      chk("R4 pointer reset", ch_load_val[47:32], 16'h2211);

      cur_req = "R2";
      bus_wr(3, 8'h3A);                 // ch0 word, mode 5
      chk("R2 mode 5 kept", ch_mode[2:0], 5);

      cur_req = "R5";
      cnt[0] = 16'hABCD; cnt[1] = 16'h4321;
      bus_rd(0, b); chk("R5 live lo", b, 8'hCD);
      bus_rd(0, b); chk("R5 live hi", b, 8'hAB);
      bus_rd(1, b); chk("R5 hi-only read", b, 8'h43);

      cur_req = "R6";
      bus_wr(3, 8'h00);                 // snapshot ch0
      cnt[0] = 16'h1111;
      bus_rd(0, b); chk("R6 frozen lo", b, 8'hCD);
      cur_req = "R7";
      bus_wr(3, 8'h00);                 // ignored while held
      cnt[0] = 16'h2222;
      bus_rd(0, b); chk("R7 second snapshot ignored", b, 8'hAB);
      cur_req = "R6";
      bus_rd(0, b); chk("R6 live after release", b, 8'h22);
      bus_rd(0, b);

      cur_req = "R8";
      cnt[0] = 16'h5678; cnt[1] = 16'h9ABC; cnt[2] = 16'h0F0E; ch_out = 3'b001;
      bus_wr(3, 8'hC6);                 // count+status, ch0 and ch1
      cnt[0] = 16'h0000; cnt[1] = 16'h0000; ch_out = 3'b000;
      bus_rd(0, b); chk("R9 status ch0", b, 8'hFA);
      bus_rd(0, b); chk("R8 frozen lo ch0", b, 8'h78);
      bus_rd(0, b); chk("R8 frozen hi ch0", b, 8'h56);
      bus_rd(1, b); chk("R9 status ch1", b, 8'h2C);
      bus_rd(1, b); chk("R8 frozen hi ch1", b, 8'h9A);
      bus_rd(1, b); chk("R8 ch1 live again", b, 8'h00);
      bus_rd(2, b); chk("R8 unselected ch2 live", b, 8'h0E);
      bus_wr(3, 8'hD4);                 // count only, ch1
      cnt[1] = 16'h7777;
      bus_rd(1, b); chk("R8 count-only read", b, 8'h00);

      cur_req = "R11";
      bus_rd(3, b); chk("R11 command address reads 0", b, 8'h00);
      repeat (3) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule